// File: doc/BRIEF.md
# UART Register and Interrupt Front-End

This block is the register layer between a 32-bit processor bus and the byte-wide transmit and receive engines of a serial port. Software sees five word registers: a data port, a baud divisor, a status word, a control word and a debug word. Writing the data port hands one byte to the transmit engine. A byte from the receive engine is latched into the data port. Each of these two events sets a sticky flag in the status word. Software clears a flag by writing a one to its bit.

The two flags are gated by two enable bits in the control word and merged into a single level interrupt. While a received byte is still flagged as unread, the receive engine is held off. The divisor, the pass-through enable and the break enable are plain storage, and the block drives them out to the serial engines. An access to a word beyond the map, or to an address that is not word aligned, has no effect. Such an access reads back as zero and raises a one-cycle error pulse.

Top module: `uart_regfront`

## Requirements
- R1: After reset every register reads zero except status, which reads 1; `irq`, `txValid` and `busErr` are 0 and `rxReady` is 1.
- R2: The word index is the byte address divided by four: data=0, divisor=1, status=2, control=3, debug=4. Divisor, control and debug store and return all 32 written bits.
- R3: Status bit 0 (transmitter empty) always reads 1 and no write changes it. Bit 1 is the receive event and bit 2 is the transmit event; all other status bits read 0.
- R4: A write to the data register gives `txValid`=1 with `txData` equal to write data bits 7:0 in the cycle after the request, for one cycle, and sets the transmit event. It does not change the value read from the data register.
- R5: When `rxValid` and `rxReady` are both high at a clock edge, `rxData` is stored in the data register (read back zero-extended) and the receive event is set.
- R6: `rxReady` is the inverse of the receive event. A byte offered while `rxReady` is low is ignored.
- R7: A status write clears each event bit whose written bit (1 for receive, 2 for transmit) is 1 and leaves the others unchanged.
- R8: `irq` = (control bit 0 AND receive event) OR (control bit 1 AND transmit event), valid in the cycle after the edge that updates either operand.
- R9: An access to word index 5 or above changes nothing, returns zero read data and gives `busErr`=1 for one cycle after the request.
- R10: Read data appears on `busRdata` in the cycle after a read request and holds until the next read.
- R11: `divisor` mirrors the divisor register, `thruEn` mirrors control bit 2 and `breakEn` mirrors debug bit 0.
- R12: An access whose address bits 1:0 are not zero is illegal and behaves as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Bus request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Registered read data |
| busErr | output | 1 | One-cycle pulse after an illegal access |
| txValid | output | 1 | Byte strobe to the transmit engine |
| txData | output | BYTE_W | Byte to transmit |
| rxValid | input | 1 | Receive engine offers a byte |
| rxData | input | BYTE_W | Received byte |
| rxReady | output | 1 | Block can accept a received byte |
| irq | output | 1 | Combined level interrupt |
| divisor | output | DATA_W | Baud divisor value |
| thruEn | output | 1 | Pass-through enable |
| breakEn | output | 1 | Break enable |

## Verification
The bench builds the block with ADDR_W=5. With that width every word index from 0 to 7 and every misaligned offset can be addressed, so the full legal map and the whole illegal range around it are swept. All 256 receive byte values go through capture, blocking and clearing. All sixteen combinations of the two enables and two event flags are applied against the interrupt equation, and each storage register gets walking-one and walking-zero patterns.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;
  localparam int NUM_REGS = 5;

  // status bit positions
  localparam int ST_THRE  = 0;
  localparam int ST_RXEVT = 1;
  localparam int ST_TXEVT = 2;
  // control bit positions
  localparam int CT_RXIE  = 0;
  localparam int CT_TXIE  = 1;
  localparam int CT_THRU  = 2;
  // debug bit positions
  localparam int DB_BREAK = 0;

  typedef struct packed {
    logic data;
    logic div;
    logic stat;
    logic ctrl;
    logic dbg;
  } regHit_t;

  typedef struct packed {
    regHit_t wr;
    regHit_t rd;
    logic    rdAny;   // any read request, legal or not
  } busStrobe_t;
endpackage

// File: rtl/uart_regfront_ctrl.sv
module uart_regfront_ctrl
  import uart_regfront_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe,
  output logic              busErr
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]    wordIdx;
  logic                aligned;
  logic                inMap;
  logic [NUM_REGS-1:0] hitVec;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign inMap   = aligned && (wordIdx < IDX_W'(NUM_REGS));

  for (genvar g = 0; g < NUM_REGS; g++) begin : gHit
    assign hitVec[g] = busValid && aligned && (wordIdx == IDX_W'(g));
  end

  assign strobe.wr.data = hitVec[0] && busWrite;
  assign strobe.wr.div  = hitVec[1] && busWrite;
  assign strobe.wr.stat = hitVec[2] && busWrite;
  assign strobe.wr.ctrl = hitVec[3] && busWrite;
  assign strobe.wr.dbg  = hitVec[4] && busWrite;
  assign strobe.rd.data = hitVec[0] && !busWrite;
  assign strobe.rd.div  = hitVec[1] && !busWrite;
  assign strobe.rd.stat = hitVec[2] && !busWrite;
  assign strobe.rd.ctrl = hitVec[3] && !busWrite;
  assign strobe.rd.dbg  = hitVec[4] && !busWrite;
  assign strobe.rdAny   = busValid && !busWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busErr <= 1'b0;
    else       busErr <= busValid && !inMap;
  end

  // R9 / R12: an error pulse only ever follows a bus request
  a_r9_err_follows_request: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busValid));
endmodule

// File: rtl/uart_regfront_dp.sv
module uart_regfront_dp
  import uart_regfront_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  output logic              rxReady,
  output logic              irq,
  output logic [DATA_W-1:0] divisor,
  output logic              thruEn,
  output logic              breakEn
);
  logic [BYTE_W-1:0] dataReg;
  logic [DATA_W-1:0] divReg, ctrlReg, dbgReg;
  logic              rxEvt, txEvt;
  logic              rxTake;
  logic [DATA_W-1:0] statWord, readMux;

  assign rxReady = !rxEvt;
  assign rxTake  = rxValid && !rxEvt;

  always_comb begin
    statWord           = '0;
    statWord[ST_THRE]  = 1'b1;
    statWord[ST_RXEVT] = rxEvt;
    statWord[ST_TXEVT] = txEvt;
  end

  always_comb begin
    readMux = '0;
    if      (strobe.rd.data) readMux = DATA_W'(dataReg);
    else if (strobe.rd.div)  readMux = divReg;
    else if (strobe.rd.stat) readMux = statWord;
    else if (strobe.rd.ctrl) readMux = ctrlReg;
    else if (strobe.rd.dbg)  readMux = dbgReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      divReg   <= '0;
      ctrlReg  <= '0;
      dbgReg   <= '0;
      rxEvt    <= 1'b0;
      txEvt    <= 1'b0;
      txValid  <= 1'b0;
      txData   <= '0;
      busRdata <= '0;
    end else begin
      if (strobe.wr.div)  divReg  <= busWdata;
      if (strobe.wr.ctrl) ctrlReg <= busWdata;
      if (strobe.wr.dbg)  dbgReg  <= busWdata;
      if (rxTake)         dataReg <= rxData;
      rxEvt   <= rxTake | (rxEvt & ~(strobe.wr.stat & busWdata[ST_RXEVT]));
      txEvt   <= strobe.wr.data | (txEvt & ~(strobe.wr.stat & busWdata[ST_TXEVT]));
      txValid <= strobe.wr.data;
      if (strobe.wr.data) txData <= busWdata[BYTE_W-1:0];
      if (strobe.rdAny)   busRdata <= readMux;
    end
  end

  assign irq     = (ctrlReg[CT_RXIE] & rxEvt) | (ctrlReg[CT_TXIE] & txEvt);
  assign divisor = divReg;
  assign thruEn  = ctrlReg[CT_THRU];
  assign breakEn = dbgReg[DB_BREAK];

  // R4: a data write launches a byte and flags the transmit event
  a_r4_tx_launch: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wr.data |=> (txValid && txEvt));
  // R5: an accepted byte is captured and flagged
  a_r5_rx_capture: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxReady) |=> (rxEvt && dataReg == $past(rxData)));
  // R6: a byte offered while held off leaves the data register alone
  a_r6_rx_held_off: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> $stable(dataReg));
  // R7: writing one to the receive event bit clears it
  a_r7_w1c_rx: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wr.stat && busWdata[ST_RXEVT] && !rxTake) |=> !rxEvt);
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  output logic              rxReady,
  output logic              irq,
  output logic [DATA_W-1:0] divisor,
  output logic              thruEn,
  output logic              breakEn
);
  busStrobe_t strobe;

  uart_regfront_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .strobe(strobe), .busErr(busErr)
  );

  uart_regfront_dp #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .busRdata(busRdata), .txValid(txValid), .txData(txData),
    .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady), .irq(irq),
    .divisor(divisor), .thruEn(thruEn), .breakEn(breakEn)
  );

  // R9 / R12: an illegal access launches no byte
  a_r12_err_no_tx: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> !txValid);
endmodule

// File: tb/tb_uart_regfront.sv
`timescale 1ns/1ps
module tb_uart_regfront;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic busErr, txValid, rxReady, irq, thruEn, breakEn;
  logic [BYTE_W-1:0] txData;
  logic rxValid = 1'b0;
  logic [BYTE_W-1:0] rxData = '0;
  logic [DATA_W-1:0] divisor;

  int nVec = 0, nBad = 0;

  always #2.5 clk = ~clk;

  uart_regfront #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)) dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr),
    .txValid(txValid), .txData(txData), .rxValid(rxValid), .rxData(rxData),
    .rxReady(rxReady), .irq(irq), .divisor(divisor), .thruEn(thruEn), .breakEn(breakEn)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(logic wr, int byteAddr, logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = ADDR_W'(byteAddr); busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic regWr(int idx, logic [31:0] d);
    access(1'b1, idx * 4, d);
  endtask

  task automatic regRd(int idx, output logic [31:0] d);
    access(1'b0, idx * 4, '0);
    d = busRdata;
  endtask

  task automatic rxPush(logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1; rxData = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  initial begin
    #1000000;
    nBad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [31:0] p;
    logic [7:0]  lastRx;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rxReady", 32'(rxReady), 1);
    chk("R1 txValid", 32'(txValid), 0);
    chk("R1 busErr", 32'(busErr), 0);
    for (int i = 0; i < 5; i++) begin
      regRd(i, r);
      chk("R1 reset read", r, (i == 2) ? 32'd1 : 32'd0);
    end

    // R2 / R11 storage registers, walking one and walking zero
    for (int k = 0; k < 32; k++) begin
      for (int inv = 0; inv < 2; inv++) begin
        p = (inv == 1) ? ~(32'h1 << k) : (32'h1 << k);
        regWr(1, p); regRd(1, r);
        chk("R2 divisor readback", r, p);
        chk("R11 divisor out", divisor, p);
        regWr(3, p); regRd(3, r);
        chk("R2 control readback", r, p);
        chk("R11 thruEn", 32'(thruEn), 32'(p[2]));
        regWr(4, p); regRd(4, r);
        chk("R2 debug readback", r, p);
        chk("R11 breakEn", 32'(breakEn), 32'(p[0]));
      end
    end
    regWr(3, 0); regWr(4, 0);
    regWr(1, 32'h1234_5678);

    // R3 transmitter-empty bit cannot be written
    regWr(2, 32'hFFFF_FFFF); regRd(2, r);
    chk("R3 status after all-ones", r, 1);
    regWr(2, 0); regRd(2, r);
    chk("R3 status after zero", r, 1);

    // R4 transmit path
    lastRx = 8'h00;
    for (int b = 0; b < 256; b += 17) begin
      regWr(0, {24'hABCDEF, 8'(b)});
      chk("R4 txValid", 32'(txValid), 1);
      chk("R4 txData", 32'(txData), 32'(b));
      chk("R1 busErr legal", 32'(busErr), 0);
      @(negedge clk);
      chk("R4 txValid one cycle", 32'(txValid), 0);
      regRd(2, r);
      chk("R4 tx event set", r, 32'h5);
      regRd(0, r);
      chk("R4 data unchanged", r, 32'(lastRx));
      regWr(2, 32'h4); regRd(2, r);
      chk("R7 tx clear", r, 1);
    end

    // R5 / R6 receive path, every byte value
    for (int b = 0; b < 256; b++) begin
      rxPush(8'(b));
      chk("R6 rxReady low", 32'(rxReady), 0);
      regRd(2, r);
      chk("R5 rx event set", r, 32'h3);
      rxPush(~8'(b));
      regRd(0, r);
      chk("R6 held-off byte ignored", r, 32'(b));
      regWr(2, 32'h2);
      chk("R6 rxReady after clear", 32'(rxReady), 1);
      regRd(2, r);
      chk("R7 rx clear", r, 1);
    end
    lastRx = 8'hFF;

    // R7 selective clearing
    rxPush(8'h3C); regWr(0, 32'h55);
    regRd(2, r); chk("R7 both set", r, 32'h7);
    regWr(2, 32'h0); regRd(2, r); chk("R7 zero write keeps", r, 32'h7);
    regWr(2, 32'h4); regRd(2, r); chk("R7 clear tx only", r, 32'h3);
    regWr(0, 32'h66);
    regWr(2, 32'h2); regRd(2, r); chk("R7 clear rx only", r, 32'h5);
    regWr(2, 32'h6); regRd(2, r); chk("R7 clear both", r, 32'h1);

    // R8 interrupt equation, all 16 combinations
    for (int m = 0; m < 16; m++) begin
      regWr(2, 32'h6);
      regWr(3, 32'(m & 3));
      if (m[2]) rxPush(8'(m));
      if (m[3]) regWr(0, 32'(m));
      chk("R8 irq level", 32'(irq), 32'((m[0] & m[2]) | (m[1] & m[3])));
      regWr(2, 32'h6);
      chk("R8 irq after clear", 32'(irq), 0);
    end
    regWr(3, 32'h3);
    rxPush(8'h81);
    chk("R8 irq on rx", 32'(irq), 1);
    regWr(3, 32'h2);
    chk("R8 irq on disable", 32'(irq), 0);
    regWr(2, 32'h6);
    regWr(3, 0);
    lastRx = 8'h81;

    // R9 out-of-map indices
    for (int i = 5; i < 8; i++) begin
      regRd(1, r);
      regWr(i, 32'hFFFF_FFFF);
      chk("R9 busErr write", 32'(busErr), 1);
      chk("R9 no tx", 32'(txValid), 0);
      @(negedge clk);
      chk("R9 busErr one cycle", 32'(busErr), 0);
      regRd(i, r);
      chk("R9 busErr read", 32'(busErr), 1);
      chk("R9 read zero", r, 0);
      regRd(1, r); chk("R9 divisor untouched", r, 32'h1234_5678);
      regRd(2, r); chk("R9 status untouched", r, 1);
      regRd(3, r); chk("R9 control untouched", r, 0);
      regRd(4, r); chk("R9 debug untouched", r, 0);
      regRd(0, r); chk("R9 data untouched", r, 32'(lastRx));
    end

    // R12 misaligned addresses
    for (int i = 0; i < 5; i++) begin
      for (int off = 1; off < 4; off++) begin
        access(1'b1, i * 4 + off, 32'hFFFF_FFFF);
        chk("R12 busErr", 32'(busErr), 1);
        chk("R12 no tx", 32'(txValid), 0);
        access(1'b0, i * 4 + off, 0);
        chk("R12 read zero", busRdata, 0);
      end
    end
    regRd(1, r); chk("R12 divisor untouched", r, 32'h1234_5678);
    regRd(2, r); chk("R12 status untouched", r, 1);
    regRd(3, r); chk("R12 control untouched", r, 0);
    regRd(4, r); chk("R12 debug untouched", r, 0);

    // R10 read data holds between reads
    regRd(1, r);
    chk("R10 read value", r, 32'h1234_5678);
    regWr(4, 32'hDEAD_BEEF);
    repeat (3) @(negedge clk);
    chk("R10 read data holds", busRdata, 32'h1234_5678);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule